// File: doc/BRIEF.md
# Deferred-Binding Register Rename Table

This block renames architectural registers for an out-of-order core without tying up storage at decode. A decoded destination receives a tag from a pool of storage-free virtual tags. A physical register is drawn from a separate pool only when the instruction finishes execution. Two tables record the state:
- The logical map has one entry per logical register. Each entry holds the newest tag, the physical register bound to it, and a bound flag.
- The tag map has one entry per tag. It records which physical register, if any, the tag was given.

Each cycle the block can do four things. It renames two sources and one destination. It binds one completing tag. It retires one instruction, which releases the tag its destination replaced together with that tag's physical register. It unwinds one speculative mapping, newest first. Rollback and decode are never requested in the same cycle.

All results are combinational from the state held at the start of the cycle. State changes at the rising clock edge. The tag pool has as many entries as logical registers plus window slots, so a decode within the window always finds a tag.

Top module: `vpr_rename_top`

## Requirements
- R1: After reset, logical register i maps to tag i and physical register i, with the bound flag set. A source naming it returns id i with ready = 1. Tags NLR..NVR-1 and physical registers NLR..NPR-1 start free.
- R2: A source whose entry is bound returns the physical register with ready = 1. An unbound source returns the tag with ready = 0. Sources read the state that held before this cycle's destination update.
- R3: A decode with a destination takes the lowest-numbered free tag, reports it on dec_dst_tag, and reports the replaced tag on dec_prev_tag. The entry then holds the new tag and is unbound.
- R4: A completion takes the lowest-numbered free physical register and reports it on cmp_preg. The completing tag is recorded as bound to it. If the logical entry still holds that tag, the entry becomes bound to that register.
- R5: A completion whose tag is no longer the newest for its logical register leaves the logical entry unchanged.
- R6: A commit releases the given previous tag and, if it is bound, its physical register. Both become available to later allocations at their index order.
- R7: A rollback releases the entry's current tag and, if the entry is bound, its physical register. It then restores the given previous tag. The entry is bound to that tag's physical register when the tag map shows the tag as bound.
- R8: A rollback to a previous tag that was never bound leaves the entry unbound. Its sources then return that tag with ready = 0.
- R9: A completion while no physical register is free drives cmp_fail = 1. It allocates nothing and changes no table.
- R10: A completion in the same cycle as a decode is forwarded to the sources. A source whose entry holds the completing tag returns the new physical register with ready = 1. A destination renamed in that cycle for the same logical register overrides the completion's binding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decode request |
| dec_src0_lr | input | LW | First source logical register |
| dec_src1_lr | input | LW | Second source logical register |
| dec_dst_en | input | 1 | Decode carries a destination |
| dec_dst_lr | input | LW | Destination logical register |
| dec_src0_id | output | TW | First source physical register or tag |
| dec_src0_rdy | output | 1 | First source id is a physical register |
| dec_src1_id | output | TW | Second source physical register or tag |
| dec_src1_rdy | output | 1 | Second source id is a physical register |
| dec_dst_tag | output | TW | Tag given to the destination |
| dec_prev_tag | output | TW | Tag replaced by the destination |
| cmp_valid | input | 1 | Completion request |
| cmp_lr | input | LW | Logical destination of the completing instruction |
| cmp_tag | input | TW | Tag of the completing instruction |
| cmp_preg | output | PW | Physical register bound on completion |
| cmp_fail | output | 1 | Completion refused, no free physical register |
| cmt_valid | input | 1 | Commit request |
| cmt_prev_tag | input | TW | Previous tag saved for the committing instruction |
| rb_valid | input | 1 | Rollback of one mapping |
| rb_lr | input | LW | Logical destination being unwound |
| rb_prev_tag | input | TW | Previous tag to restore |

## Verification
Two same-cycle overlaps matter most. The first is a completion arriving while a decode reads the logical register being bound. The second is a decode renaming that same register while the completion binds it. Both are provoked by driving a completion for a pending tag together with a decode in one cycle. The source output must show the new physical register as ready in that very cycle. On the next cycle, a read of the same register must show the decode's fresh, unbound tag.

// File: rtl/vpr_pkg.sv
// Package: default sizes and a width helper shared by the rename table.
// Assumes the tag count is at least the physical register count.
package vpr_pkg;
    localparam int NLR_DEF = 8;
    localparam int WIN_DEF = 8;
    localparam int NPR_DEF = 12;

    function automatic int idx_w(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/vpr_free_pool.sv
// Free pool: bitmap of free ids; hands out the lowest free id and takes back
// up to two ids per cycle. Assumes released ids are currently in use.
module vpr_free_pool #(
    parameter int N         = 16,
    parameter int INIT_USED = 8,
    localparam int IW       = vpr_pkg::idx_w(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_req,
    output logic          alloc_ok,
    output logic [IW-1:0] alloc_id,
    output logic          empty,
    input  logic          rel_a_v,
    input  logic [IW-1:0] rel_a_id,
    input  logic          rel_b_v,
    input  logic [IW-1:0] rel_b_id
);
    logic [N-1:0] free_q;

    // Pick the lowest-numbered free id.
    always_comb begin
        alloc_id = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_q[i]) alloc_id = IW'(i);
        end
        empty    = (free_q == '0);
        alloc_ok = alloc_req && !empty;
    end

    // Update the bitmap for this cycle's allocation and releases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) free_q[i] <= (i >= INIT_USED);
        end else begin
            if (alloc_ok) free_q[alloc_id] <= 1'b0;
            if (rel_a_v)  free_q[rel_a_id] <= 1'b1;
            if (rel_b_v)  free_q[rel_b_id] <= 1'b1;
        end
    end

    AST_NO_DOUBLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        rel_a_v |-> !free_q[rel_a_id]); // R6
    AST_NO_DOUBLE_FREE_B: assert property (@(posedge clk) disable iff (!rst_n)
        rel_b_v |-> !free_q[rel_b_id]); // R7
    AST_FREE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(free_q) == $countones($past(free_q))
            - int'($past(alloc_ok)) + int'($past(rel_a_v)) + int'($past(rel_b_v)))); // R6
endmodule

// File: rtl/vpr_tag_map.sv
// Tag map: per tag, the bound flag and the physical register it was given.
// Written on completion, cleared when a tag returns to its pool.
module vpr_tag_map #(
    parameter int NVR = 16,
    parameter int NLR = 8,
    parameter int NPR = 12,
    localparam int TW = vpr_pkg::idx_w(NVR),
    localparam int PW = vpr_pkg::idx_w(NPR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_v,
    input  logic [TW-1:0] wr_tag,
    input  logic [PW-1:0] wr_preg,
    input  logic          clr_a_v,
    input  logic [TW-1:0] clr_a_tag,
    input  logic          clr_b_v,
    input  logic [TW-1:0] clr_b_tag,
    input  logic [TW-1:0] rd_a_tag,
    output logic          rd_a_bound,
    output logic [PW-1:0] rd_a_preg,
    input  logic [TW-1:0] rd_b_tag,
    output logic          rd_b_bound,
    output logic [PW-1:0] rd_b_preg
);
    logic [NVR-1:0]         bound_q;
    logic [NVR-1:0][PW-1:0] preg_q;

    // Two independent read ports.
    always_comb begin
        rd_a_bound = bound_q[rd_a_tag];
        rd_a_preg  = preg_q[rd_a_tag];
        rd_b_bound = bound_q[rd_b_tag];
        rd_b_preg  = preg_q[rd_b_tag];
    end

    // Bind on completion, unbind on release; reset binds tag i to register i.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NVR; i++) begin
                bound_q[i] <= (i < NLR);
                preg_q[i]  <= (i < NLR) ? PW'(i) : '0;
            end
        end else begin
            if (wr_v) begin
                bound_q[wr_tag] <= 1'b1;
                preg_q[wr_tag]  <= wr_preg;
            end
            if (clr_a_v) bound_q[clr_a_tag] <= 1'b0;
            if (clr_b_v) bound_q[clr_b_tag] <= 1'b0;
        end
    end

    AST_BIND_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_v |-> !bound_q[wr_tag]); // R4
endmodule

// File: rtl/vpr_logic_map.sv
// Logical map: per logical register the newest tag, its physical register and
// a bound flag. Write order: completion, then decode, then rollback.
// Assumes decode and rollback never occur in the same cycle.
module vpr_logic_map #(
    parameter int NLR = 8,
    parameter int NVR = 16,
    parameter int NPR = 12,
    localparam int LW = vpr_pkg::idx_w(NLR),
    localparam int TW = vpr_pkg::idx_w(NVR),
    localparam int PW = vpr_pkg::idx_w(NPR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] rd_lr [4],
    output logic [TW-1:0] rd_tag [4],
    output logic [PW-1:0] rd_preg [4],
    output logic          rd_vld [4],
    input  logic          cmp_ok,
    input  logic          cmp_fail,
    input  logic [LW-1:0] cmp_lr,
    input  logic [TW-1:0] cmp_tag,
    input  logic [PW-1:0] cmp_preg,
    input  logic          dst_v,
    input  logic [LW-1:0] dst_lr,
    input  logic [TW-1:0] dst_tag,
    input  logic          rb_v,
    input  logic [LW-1:0] rb_lr,
    input  logic [TW-1:0] rb_tag,
    input  logic          rb_bound,
    input  logic [PW-1:0] rb_preg
);
    logic [NLR-1:0][TW-1:0] tag_q;
    logic [NLR-1:0][PW-1:0] preg_q;
    logic [NLR-1:0]         vld_q;
    logic                   cmp_match;

    // Read ports: two sources, destination, rollback.
    for (genvar g = 0; g < 4; g++) begin : g_rd
        assign rd_tag[g]  = tag_q[rd_lr[g]];
        assign rd_preg[g] = preg_q[rd_lr[g]];
        assign rd_vld[g]  = vld_q[rd_lr[g]];
    end

    // A completion binds only if its tag is still the newest.
    assign cmp_match = cmp_ok && (tag_q[cmp_lr] == cmp_tag);

    // Apply completion, decode and rollback updates in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLR; i++) begin
                tag_q[i]  <= TW'(i);
                preg_q[i] <= PW'(i);
                vld_q[i]  <= 1'b1;
            end
        end else begin
            if (cmp_match) begin
                preg_q[cmp_lr] <= cmp_preg;
                vld_q[cmp_lr]  <= 1'b1;
            end
            if (dst_v) begin
                tag_q[dst_lr] <= dst_tag;
                vld_q[dst_lr] <= 1'b0;
            end else if (rb_v) begin
                tag_q[rb_lr]  <= rb_tag;
                preg_q[rb_lr] <= rb_preg;
                vld_q[rb_lr]  <= rb_bound;
            end
        end
    end

    AST_BIND_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_match && !(dst_v && dst_lr == cmp_lr) && !rb_v) |=> vld_q[$past(cmp_lr)]); // R4
    AST_FAIL_KEEPS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_fail && !dst_v && !rb_v) |=> ($stable(tag_q) && $stable(preg_q) && $stable(vld_q))); // R9
    AST_DECODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        dst_v |=> !vld_q[$past(dst_lr)]); // R3
endmodule

// File: rtl/vpr_rename_top.sv
// Deferred-binding rename table: renames at decode with storage-free tags,
// binds physical registers at completion, frees at commit, unwinds on rollback.
// Assumes NPR <= NVR and no decode in a rollback cycle.
module vpr_rename_top #(
    parameter int NLR  = vpr_pkg::NLR_DEF,
    parameter int WIN  = vpr_pkg::WIN_DEF,
    parameter int NPR  = vpr_pkg::NPR_DEF,
    localparam int NVR = NLR + WIN,
    localparam int LW  = vpr_pkg::idx_w(NLR),
    localparam int TW  = vpr_pkg::idx_w(NVR),
    localparam int PW  = vpr_pkg::idx_w(NPR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic [LW-1:0] dec_src0_lr,
    input  logic [LW-1:0] dec_src1_lr,
    input  logic          dec_dst_en,
    input  logic [LW-1:0] dec_dst_lr,
    output logic [TW-1:0] dec_src0_id,
    output logic          dec_src0_rdy,
    output logic [TW-1:0] dec_src1_id,
    output logic          dec_src1_rdy,
    output logic [TW-1:0] dec_dst_tag,
    output logic [TW-1:0] dec_prev_tag,
    input  logic          cmp_valid,
    input  logic [LW-1:0] cmp_lr,
    input  logic [TW-1:0] cmp_tag,
    output logic [PW-1:0] cmp_preg,
    output logic          cmp_fail,
    input  logic          cmt_valid,
    input  logic [TW-1:0] cmt_prev_tag,
    input  logic          rb_valid,
    input  logic [LW-1:0] rb_lr,
    input  logic [TW-1:0] rb_prev_tag
);
    logic          dst_v, tag_empty, preg_empty, cmp_ok;
    logic [LW-1:0] rd_lr [4];
    logic [TW-1:0] rd_tag [4];
    logic [PW-1:0] rd_preg [4];
    logic          rd_vld [4];
    logic          cmt_bound, rbp_bound;
    logic [PW-1:0] cmt_preg, rbp_preg;
    logic          rb_cur_bound;

    assign dst_v    = dec_valid && dec_dst_en;
    assign rd_lr[0] = dec_src0_lr;
    assign rd_lr[1] = dec_src1_lr;
    assign rd_lr[2] = dec_dst_lr;
    assign rd_lr[3] = rb_lr;
    assign rb_cur_bound = rb_valid && rd_vld[3];

    // Resolve each source, forwarding a same-cycle completion of its tag.
    always_comb begin
        dec_src0_rdy = rd_vld[0];
        dec_src0_id  = rd_vld[0] ? TW'(rd_preg[0]) : rd_tag[0];
        if (cmp_ok && cmp_lr == dec_src0_lr && rd_tag[0] == cmp_tag) begin
            dec_src0_rdy = 1'b1;
            dec_src0_id  = TW'(cmp_preg);
        end
        dec_src1_rdy = rd_vld[1];
        dec_src1_id  = rd_vld[1] ? TW'(rd_preg[1]) : rd_tag[1];
        if (cmp_ok && cmp_lr == dec_src1_lr && rd_tag[1] == cmp_tag) begin
            dec_src1_rdy = 1'b1;
            dec_src1_id  = TW'(cmp_preg);
        end
        dec_prev_tag = rd_tag[2];
        cmp_fail     = cmp_valid && preg_empty;
    end

    vpr_free_pool #(.N(NVR), .INIT_USED(NLR)) u_tag_pool (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(dst_v), .alloc_ok(), .alloc_id(dec_dst_tag), .empty(tag_empty),
        .rel_a_v(cmt_valid), .rel_a_id(cmt_prev_tag),
        .rel_b_v(rb_valid), .rel_b_id(rd_tag[3])
    );

    vpr_free_pool #(.N(NPR), .INIT_USED(NLR)) u_preg_pool (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(cmp_valid), .alloc_ok(cmp_ok), .alloc_id(cmp_preg), .empty(preg_empty),
        .rel_a_v(cmt_valid && cmt_bound), .rel_a_id(cmt_preg),
        .rel_b_v(rb_cur_bound), .rel_b_id(rd_preg[3])
    );

    vpr_tag_map #(.NVR(NVR), .NLR(NLR), .NPR(NPR)) u_tag_map (
        .clk(clk), .rst_n(rst_n),
        .wr_v(cmp_ok), .wr_tag(cmp_tag), .wr_preg(cmp_preg),
        .clr_a_v(cmt_valid), .clr_a_tag(cmt_prev_tag),
        .clr_b_v(rb_valid), .clr_b_tag(rd_tag[3]),
        .rd_a_tag(cmt_prev_tag), .rd_a_bound(cmt_bound), .rd_a_preg(cmt_preg),
        .rd_b_tag(rb_prev_tag), .rd_b_bound(rbp_bound), .rd_b_preg(rbp_preg)
    );

    vpr_logic_map #(.NLR(NLR), .NVR(NVR), .NPR(NPR)) u_logic_map (
        .clk(clk), .rst_n(rst_n),
        .rd_lr(rd_lr), .rd_tag(rd_tag), .rd_preg(rd_preg), .rd_vld(rd_vld),
        .cmp_ok(cmp_ok), .cmp_fail(cmp_fail), .cmp_lr(cmp_lr), .cmp_tag(cmp_tag),
        .cmp_preg(cmp_preg),
        .dst_v(dst_v), .dst_lr(dec_dst_lr), .dst_tag(dec_dst_tag),
        .rb_v(rb_valid), .rb_lr(rb_lr), .rb_tag(rb_prev_tag),
        .rb_bound(rbp_bound), .rb_preg(rbp_preg)
    );

    AST_TAG_AVAILABLE: assert property (@(posedge clk) disable iff (!rst_n)
        dst_v |-> !tag_empty); // R3
    AST_NO_DECODE_IN_ROLLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid |-> !dst_v); // R7
    AST_READY_IS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !cmp_valid) |-> (dec_src0_rdy == rd_vld[0])); // R2
endmodule

// File: tb/sim_vpr_rename_top.sv
module sim_vpr_rename_top;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 3;
    localparam int TW = 4;
    localparam int PW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_valid = 0, dec_dst_en = 0;
    logic [LW-1:0] dec_src0_lr = '0, dec_src1_lr = '0, dec_dst_lr = '0;
    logic [TW-1:0] dec_src0_id, dec_src1_id, dec_dst_tag, dec_prev_tag;
    logic dec_src0_rdy, dec_src1_rdy;
    logic cmp_valid = 0;
    logic [LW-1:0] cmp_lr = '0;
    logic [TW-1:0] cmp_tag = '0;
    logic [PW-1:0] cmp_preg;
    logic cmp_fail;
    logic cmt_valid = 0;
    logic [TW-1:0] cmt_prev_tag = '0;
    logic rb_valid = 0;
    logic [LW-1:0] rb_lr = '0;
    logic [TW-1:0] rb_prev_tag = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vpr_rename_top u0 (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .dec_src0_lr(dec_src0_lr), .dec_src1_lr(dec_src1_lr),
        .dec_dst_en(dec_dst_en), .dec_dst_lr(dec_dst_lr),
        .dec_src0_id(dec_src0_id), .dec_src0_rdy(dec_src0_rdy),
        .dec_src1_id(dec_src1_id), .dec_src1_rdy(dec_src1_rdy),
        .dec_dst_tag(dec_dst_tag), .dec_prev_tag(dec_prev_tag),
        .cmp_valid(cmp_valid), .cmp_lr(cmp_lr), .cmp_tag(cmp_tag),
        .cmp_preg(cmp_preg), .cmp_fail(cmp_fail),
        .cmt_valid(cmt_valid), .cmt_prev_tag(cmt_prev_tag),
        .rb_valid(rb_valid), .rb_lr(rb_lr), .rb_prev_tag(rb_prev_tag)
    );

    typedef enum int {S0_ID, S0_RDY, S1_ID, S1_RDY, DST, PREV, CPREG, CFAIL} sig_e;
    typedef struct { string req; sig_e sig; int exp; } item_t;
    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    function automatic int observe(sig_e s);
        case (s)
            S0_ID:  return int'(dec_src0_id);
            S0_RDY: return int'(dec_src0_rdy);
            S1_ID:  return int'(dec_src1_id);
            S1_RDY: return int'(dec_src1_rdy);
            DST:    return int'(dec_dst_tag);
            PREV:   return int'(dec_prev_tag);
            CPREG:  return int'(cmp_preg);
            default: return int'(cmp_fail);
        endcase
    endfunction

    // Monitor: mid-cycle, pop every expectation pushed for this cycle.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            int act;
            it = q.pop_front();
            act = observe(it.sig);
            checks++;
            if (act != it.exp) begin
                errors++;
                $display("FAIL %s %s: actual=%0d expected=%0d", it.req, it.sig.name(), act, it.exp);
            end
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
        dec_valid = 0; dec_dst_en = 0; cmp_valid = 0; cmt_valid = 0; rb_valid = 0;
    endtask
    task automatic expect_v(string r, sig_e s, int e);
        item_t it;
        it.req = r; it.sig = s; it.exp = e;
        q.push_back(it);
    endtask
    task automatic dec(int s0, int s1, bit den, int dl);
        dec_valid = 1; dec_src0_lr = LW'(s0); dec_src1_lr = LW'(s1);
        dec_dst_en = den; dec_dst_lr = LW'(dl);
    endtask
    task automatic cmp(int lr, int tag);
        cmp_valid = 1; cmp_lr = LW'(lr); cmp_tag = TW'(tag);
    endtask
    task automatic cmt(int tag);
        cmt_valid = 1; cmt_prev_tag = TW'(tag);
    endtask
    task automatic rb(int lr, int tag);
        rb_valid = 1; rb_lr = LW'(lr); rb_prev_tag = TW'(tag);
    endtask
    task automatic src0(string r, int id, int rdy);
        expect_v(r, S0_ID, id); expect_v(r, S0_RDY, rdy);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset mapping
        cyc(); dec(3, 5, 0, 0);
        src0("R1", 3, 1); expect_v("R1", S1_ID, 5); expect_v("R1", S1_RDY, 1);
        // R3: first destination gets tag 8, replaces 2; source reads old state (R2)
        cyc(); dec(2, 0, 1, 2);
        src0("R2", 2, 1); expect_v("R3", DST, 8); expect_v("R3", PREV, 2);
        cyc(); dec(2, 2, 1, 2);
        src0("R2", 8, 0); expect_v("R3", S1_RDY, 0); expect_v("R3", DST, 9); expect_v("R3", PREV, 8);
        // R5: stale completion of tag 8
        cyc(); cmp(2, 8); dec(2, 0, 0, 0);
        expect_v("R4", CPREG, 8); expect_v("R4", CFAIL, 0); src0("R5", 9, 0);
        cyc(); dec(2, 0, 0, 0); src0("R5", 9, 0);
        // R10: forwarded completion
        cyc(); cmp(2, 9); dec(2, 0, 0, 0);
        expect_v("R4", CPREG, 9); src0("R10", 9, 1);
        cyc(); dec(2, 0, 0, 0); src0("R4", 9, 1);
        // R6: commit frees tag 2 and register 2
        cyc(); cmt(2);
        cyc(); dec(0, 0, 1, 4); expect_v("R6", DST, 2); expect_v("R6", PREV, 4);
        cyc(); cmp(4, 2); expect_v("R6", CPREG, 2);
        // R7: rollback to a bound tag
        cyc(); dec(0, 0, 1, 6); expect_v("R3", DST, 10); expect_v("R3", PREV, 6);
        cyc(); rb(6, 6);
        cyc(); dec(6, 0, 0, 0); src0("R7", 6, 1);
        cyc(); dec(0, 0, 1, 6); expect_v("R7", DST, 10);
        // R8: rollback to an unbound tag
        cyc(); dec(0, 0, 1, 6); expect_v("R3", DST, 11); expect_v("R3", PREV, 10);
        cyc(); cmp(6, 11); expect_v("R4", CPREG, 10);
        cyc(); rb(6, 10);
        cyc(); dec(6, 0, 0, 0); src0("R8", 10, 0);
        cyc(); cmp(6, 10); expect_v("R7", CPREG, 10);
        // R9: exhaust physical pool
        cyc(); dec(0, 0, 1, 7); expect_v("R7", DST, 11); expect_v("R3", PREV, 7);
        cyc(); cmp(7, 11); expect_v("R4", CPREG, 11);
        cyc(); dec(0, 0, 1, 7); expect_v("R3", DST, 12);
        cyc(); cmp(7, 12); expect_v("R9", CFAIL, 1);
        cyc(); dec(7, 0, 0, 0); src0("R9", 12, 0);
        cyc(); cmt(7);
        cyc(); cmp(7, 12); expect_v("R9", CFAIL, 0); expect_v("R6", CPREG, 7);
        cyc(); dec(7, 0, 0, 0); src0("R9", 7, 1);
        // R10: decode overrides completion on the same logical register
        cyc(); dec(0, 0, 1, 5); expect_v("R6", DST, 7); expect_v("R3", PREV, 5);
        cyc(); cmt(11);
        cyc(); cmp(5, 7); dec(5, 0, 1, 5);
        expect_v("R6", CPREG, 11); src0("R10", 11, 1); expect_v("R6", DST, 11); expect_v("R3", PREV, 7);
        cyc(); dec(5, 0, 0, 0); src0("R10", 11, 0);
        cyc();
        @(negedge clk); #1;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule